// File: doc/BRIEF.md
# SPI status flags and interrupt logic

This block is the status and interrupt section of a double-buffered SPI peripheral. It sits between a CPU register bus and an SPI shift engine. It keeps four flags: receive buffer full, overflow, mode fault and transmit buffer empty. It holds the last accepted received byte and the byte that software writes for transmission. It also holds a small control register with three interrupt enables, a mode-fault enable and a master-mode bit.

The three software-clearable flags clear only through a two-step sequence. First the status register is read while the flag is 1. Then the access that completes the clear follows as the next bus access: a data read for receive-full and overflow, a control write for mode fault. When a byte completes while the receive buffer is still full, the held byte is kept and the new byte is dropped. Mode faults are detected on the slave-select level in master mode and on a slave-select rising edge during a transfer in slave mode. Three interrupt request lines combine the flags with their enables.

Top module: `spi_stat_irq`

## Requirements
- R1: Reset clears the control register (read at address 0 as 0x00), clears receive-full, overflow and mode fault, and sets transmit-empty, so the status register (address 1) reads 0x08 and all three interrupt lines are low. Status bit 0 is receive-full, bit 1 is overflow, bit 2 is mode fault and bit 3 is transmit-empty.
- R2: A byte-complete pulse while the receive buffer is empty loads the byte into the receive register (read at address 2) and sets receive-full in the next cycle. irq_rx equals receive-full AND control bit 0.
- R3: A byte-complete pulse while receive-full stays set (no clear completing in the same cycle) sets overflow, leaves the held byte unchanged and drops the new byte.
- R4: Receive-full and overflow each clear when a status read that saw the flag at 1 is followed directly by a data read. A data read with no such preceding status read leaves both flags set.
- R5: Any bus access other than a status read, placed between the status read and the completing access, cancels the pending clear.
- R6: In master mode (control bit 4 = 1) with mode-fault enable (control bit 3) at 1, a low slave-select level sets mode fault. With mode-fault enable at 0, slave-select is ignored.
- R7: In slave mode with mode-fault enable at 1, a slave-select rising edge while a transfer is active sets mode fault. A rising edge with no active transfer does not set it.
- R8: Mode fault clears when a status read that saw it at 1 is followed directly by a control write. A control write that clears mode-fault enable without that preceding status read leaves mode fault set.
- R9: irq_err equals (overflow OR mode fault) AND control bit 2, so it is low whenever bit 2 is 0.
- R10: A data write loads tx_hold and clears transmit-empty. A transmit-load pulse sets transmit-empty. irq_tx equals transmit-empty AND control bit 1.
- R11: A set event in the same cycle as the completing clear access wins. A byte completing during the clearing data read is loaded with receive-full left at 1 and no overflow. A transmit-load during a data write leaves transmit-empty at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| rx_done | input | 1 | Byte-complete pulse from the shift engine |
| rx_byte | input | DATA_W | Byte delivered with rx_done |
| tx_load | input | 1 | Pulse when the shift engine takes the transmit byte |
| tx_hold | output | DATA_W | Byte written by software for transmission |
| ss_in | input | 1 | Slave-select pin level, already synchronous |
| xfer_active | input | 1 | Shift engine has a transfer in progress |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Two pairs of functions can meet in one cycle: the data read that completes a receive clear with a byte-complete pulse, and the data write that empties the transmit buffer with a transmit-load pulse. Directed steps line up each pair on the same edge. Random traffic then mixes byte pulses, loads and bus accesses so that the pairs also meet by chance. A collision is judged correct when the flag stays set, the new byte replaces the old one with no overflow, and tx_hold still takes the written byte.

// File: rtl/spi_si_pkg.sv
package spi_si_pkg;

  // register addresses
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_DATA = 2;

  // flags cleared by the two-step sequence
  localparam int unsigned NUM_CLR_FLAGS = 3;
  localparam int unsigned FI_RXF = 0;
  localparam int unsigned FI_OVF = 1;
  localparam int unsigned FI_MDF = 2;

  // control register, LSB is rx_ie
  typedef struct packed {
    logic master;
    logic mf_en;
    logic err_ie;
    logic tx_ie;
    logic rx_ie;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_si_access.sv
module spi_si_access
  import spi_si_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NUM_CLR_FLAGS-1:0] flags,
  output logic                     stat_rd,
  output logic                     data_rd,
  output logic                     data_wr,
  output logic                     ctrl_rd,
  output logic                     ctrl_wr,
  output logic [NUM_CLR_FLAGS-1:0] clr_req
);

  logic                     any_acc;
  logic [NUM_CLR_FLAGS-1:0] complete;
  logic [NUM_CLR_FLAGS-1:0] arm_q;
  logic [NUM_CLR_FLAGS-1:0] arm_d;

  always_comb begin
    stat_rd = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));
    data_rd = bus_rd && (bus_addr == ADDR_W'(ADR_DATA));
    ctrl_rd = bus_rd && (bus_addr == ADDR_W'(ADR_CTRL));
    data_wr = bus_wr && (bus_addr == ADDR_W'(ADR_DATA));
    ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    any_acc = bus_rd || bus_wr;
  end

  always_comb begin
    complete         = '0;
    complete[FI_RXF] = data_rd;
    complete[FI_OVF] = data_rd;
    complete[FI_MDF] = ctrl_wr;
  end

  for (genvar g = 0; g < NUM_CLR_FLAGS; g++) begin : g_arm
    always_comb begin
      arm_d[g] = arm_q[g];
      if (stat_rd) begin
        arm_d[g] = flags[g];
      end else if (any_acc) begin
        arm_d[g] = 1'b0;
      end
      clr_req[g] = arm_q[g] && complete[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else begin
      arm_q <= arm_d;
    end
  end

endmodule

// File: rtl/spi_si_rx.sv
module spi_si_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              clr_rxf,
  input  logic              clr_ovf,
  output logic              rxf,
  output logic              ovf,
  output logic [DATA_W-1:0] rx_data
);

  logic full_eff;
  logic load;
  logic ov_set;
  logic rxf_d;
  logic ovf_d;

  always_comb begin
    full_eff = rxf && !clr_rxf;
    load     = rx_done && !full_eff;
    ov_set   = rx_done && full_eff;
    rxf_d    = load || full_eff;
    ovf_d    = ov_set || (ovf && !clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf <= 1'b0;
      ovf <= 1'b0;
    end else begin
      rxf <= rxf_d;
      ovf <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (load) begin
      rx_data <= rx_byte;
    end
  end

endmodule

// File: rtl/spi_si_fault.sv
module spi_si_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_in,
  input  logic xfer_active,
  input  logic master,
  input  logic mf_en,
  input  logic clr_mdf,
  output logic mdf
);

  logic ss_q;
  logic trig_master;
  logic trig_slave;
  logic mdf_d;

  always_comb begin
    trig_master = master && !ss_in;
    trig_slave  = !master && xfer_active && ss_in && !ss_q;
    mdf_d       = (mf_en && (trig_master || trig_slave)) || (mdf && !clr_mdf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= 1'b1;
      mdf  <= 1'b0;
    end else begin
      ss_q <= ss_in;
      mdf  <= mdf_d;
    end
  end

endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_si_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_load,
  output logic [DATA_W-1:0] tx_hold,
  input  logic              ss_in,
  input  logic              xfer_active,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_err
);

  localparam int unsigned STAT_PAD = DATA_W - 4;
  localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;

  logic [SYNC_STAGES-1:0]   sync_q;
  logic                     rst_sync_n;
  logic                     stat_rd;
  logic                     data_rd;
  logic                     data_wr;
  logic                     ctrl_rd;
  logic                     ctrl_wr;
  logic [NUM_CLR_FLAGS-1:0] flags;
  logic [NUM_CLR_FLAGS-1:0] clr_req;
  logic                     rxf;
  logic                     ovf;
  logic                     mdf;
  logic [DATA_W-1:0]        rx_data;
  logic                     txe_q;
  logic                     txe_d;
  ctrl_t                    ctrl_q;
  logic                     ie_err;
  logic                     mf_en;

  // reset: asserted at once, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  always_comb begin
    flags         = '0;
    flags[FI_RXF] = rxf;
    flags[FI_OVF] = ovf;
    flags[FI_MDF] = mdf;
  end

  spi_si_access #(.ADDR_W(ADDR_W)) u_access (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .flags    (flags),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .ctrl_rd  (ctrl_rd),
    .ctrl_wr  (ctrl_wr),
    .clr_req  (clr_req)
  );

  spi_si_rx #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .clr_rxf (clr_req[FI_RXF]),
    .clr_ovf (clr_req[FI_OVF]),
    .rxf     (rxf),
    .ovf     (ovf),
    .rx_data (rx_data)
  );

  spi_si_fault u_fault (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ss_in       (ss_in),
    .xfer_active (xfer_active),
    .master      (ctrl_q.master),
    .mf_en       (ctrl_q.mf_en),
    .clr_mdf     (clr_req[FI_MDF]),
    .mdf         (mdf)
  );

  // control register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  // transmit-empty flag, load pulse wins over the emptying write
  always_comb begin
    txe_d = tx_load || (txe_q && !data_wr);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txe_q <= 1'b1;
    end else begin
      txe_q <= txe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_hold <= '0;
    end else if (data_wr) begin
      tx_hold <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (ctrl_rd) begin
      bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
    end else if (stat_rd) begin
      bus_rdata = {{STAT_PAD{1'b0}}, txe_q, mdf, ovf, rxf};
    end else if (data_rd) begin
      bus_rdata = rx_data;
    end
  end

  assign ie_err  = ctrl_q.err_ie;
  assign mf_en   = ctrl_q.mf_en;
  assign irq_rx  = rxf && ctrl_q.rx_ie;
  assign irq_tx  = txe_q && ctrl_q.tx_ie;
  assign irq_err = (ovf || mdf) && ie_err;

endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_done,
  input logic              tx_load,
  input logic              rxf,
  input logic              ovf,
  input logic              mdf,
  input logic              txe,
  input logic [DATA_W-1:0] rx_data,
  input logic              irq_err,
  input logic              ie_err,
  input logic              mf_en
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);

  logic data_rd_c;
  logic ctrl_wr_c;
  assign data_rd_c = bus_rd && (bus_addr == A_DATA);
  assign ctrl_wr_c = bus_wr && (bus_addr == A_CTRL);

  p_load_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_done |=> rxf);

  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_done && rxf && !data_rd_c) |=> ($stable(rx_data) && ovf));

  p_ovf_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf) |-> $past(rxf));

  p_rxf_clear_path_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rxf) |-> $past(data_rd_c));

  p_mf_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mdf) |-> $past(mf_en));

  p_mf_clear_path_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(mdf) |-> $past(ctrl_wr_c));

  p_err_gated_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_err |-> (ie_err && (ovf || mdf)));

  p_tx_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_load |=> txe);

endmodule

bind spi_stat_irq spi_stat_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rx_done  (rx_done),
  .tx_load  (tx_load),
  .rxf      (rxf),
  .ovf      (ovf),
  .mdf      (mdf),
  .txe      (txe_q),
  .rx_data  (rx_data),
  .irq_err  (irq_err),
  .ie_err   (ie_err),
  .mf_en    (mf_en)
);

// File: tb/spi_stat_irq_bench.sv
module spi_stat_irq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_rd, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       tx_load;
  logic [7:0] tx_hold;
  logic       ss_in, xfer_active;
  logic       irq_rx, irq_tx, irq_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the requirements
  logic       m_rxf, m_ovf, m_mf, m_txe, m_ssq;
  logic [7:0] m_rxd, m_txh;
  logic [4:0] m_ctrl;
  logic [2:0] m_arm;

  always #5 clk = ~clk;

  spi_stat_irq u_spi_stat_irq (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_byte(rx_byte), .tx_load(tx_load), .tx_hold(tx_hold),
    .ss_in(ss_in), .xfer_active(xfer_active),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {3'b0, m_ctrl};
      2'd1:    return {4'b0, m_txe, m_mf, m_ovf, m_rxf};
      2'd2:    return m_rxd;
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: drive at a falling edge, advance model, compare at the next falling edge
  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic rxd, input logic [7:0] rxb,
                      input logic txl, input logic xa, output logic [7:0] rdat);
    logic st, dr, dw, cw, acc, clr_rx, clr_ov, clr_mf, full_eff, ld, mset;
    logic n_rxf, n_ovf, n_mf, n_txe;
    logic [7:0] n_rxd, n_txh;
    logic [4:0] n_ctrl;
    logic [2:0] n_arm;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_done = rxd; rx_byte = rxb; tx_load = txl; xfer_active = xa;
    #1;
    rdat = bus_rdata;
    if (rd) chk("R4 read data", rdat, m_read(a));
    st = rd && a == 2'd1; dr = rd && a == 2'd2;
    dw = wr && a == 2'd2; cw = wr && a == 2'd0; acc = rd || wr;
    clr_rx = dr && m_arm[0]; clr_ov = dr && m_arm[1]; clr_mf = cw && m_arm[2];
    full_eff = m_rxf && !clr_rx;
    ld = rxd && !full_eff;
    n_rxf = ld || full_eff;
    n_rxd = ld ? rxb : m_rxd;
    n_ovf = (rxd && full_eff) || (m_ovf && !clr_ov);
    mset = m_ctrl[3] && (m_ctrl[4] ? !ss_in : (xa && ss_in && !m_ssq));
    n_mf = mset || (m_mf && !clr_mf);
    n_txe = txl || (m_txe && !dw);
    n_txh = dw ? wd : m_txh;
    n_ctrl = cw ? wd[4:0] : m_ctrl;
    n_arm = st ? {m_mf, m_ovf, m_rxf} : (acc ? 3'b000 : m_arm);
    @(negedge clk);
    m_rxf = n_rxf; m_rxd = n_rxd; m_ovf = n_ovf; m_mf = n_mf; m_txe = n_txe;
    m_txh = n_txh; m_ctrl = n_ctrl; m_arm = n_arm; m_ssq = ss_in;
    bus_rd = 0; bus_wr = 0; rx_done = 0; tx_load = 0;
    chk("R2 irq_rx", irq_rx, m_rxf && m_ctrl[0]);
    chk("R10 irq_tx", irq_tx, m_txe && m_ctrl[1]);
    chk("R9 irq_err", irq_err, (m_ovf || m_mf) && m_ctrl[2]);
    chk("R10 tx_hold", tx_hold, m_txh);
  endtask

  task automatic rdr(input logic [1:0] a, output logic [7:0] d);
    step(1, 0, a, 8'h00, 0, 8'h00, 0, 0, d);
  endtask
  task automatic wrr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] x;
    step(0, 1, a, d, 0, 8'h00, 0, 0, x);
  endtask
  task automatic rxb(input logic [7:0] b);
    logic [7:0] x;
    step(0, 0, 2'd0, 8'h00, 1, b, 0, 0, x);
  endtask
  task automatic idle(input logic xa);
    logic [7:0] x;
    step(0, 0, 2'd0, 8'h00, 0, 8'h00, 0, xa, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_done = 0; rx_byte = 0; tx_load = 0; ss_in = 1; xfer_active = 0;
    m_rxf = 0; m_ovf = 0; m_mf = 0; m_txe = 1; m_ssq = 1;
    m_rxd = 0; m_txh = 0; m_ctrl = 0; m_arm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq lines", {irq_rx, irq_tx, irq_err}, 3'b000);
    rdr(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
    rdr(2'd1, d); chk("R1 status reset", d, 8'h08);

    // R2 receive and R4 clear
    wrr(2'd0, 8'h01);
    rxb(8'hA5);
    chk("R2 irq_rx set", irq_rx, 1'b1);
    rdr(2'd1, d); chk("R2 status full", d, 8'h09);
    rdr(2'd2, d); chk("R2 byte", d, 8'hA5);
    rdr(2'd1, d); chk("R4 cleared", d, 8'h08);

    // R4 data read without armed status read
    rxb(8'h11);
    rdr(2'd2, d); chk("R4 byte", d, 8'h11);
    rdr(2'd1, d); chk("R4 not cleared", d, 8'h09);

    // R3 overflow keeps old byte
    rxb(8'h22);
    rdr(2'd1, d); chk("R3 status ovf", d, 8'h0B);
    rdr(2'd2, d); chk("R3 held byte", d, 8'h11);
    rdr(2'd1, d); chk("R4 both cleared", d, 8'h08);

    // R5 intervening access cancels
    rxb(8'h33);
    rdr(2'd1, d); rdr(2'd0, d); rdr(2'd2, d);
    rdr(2'd1, d); chk("R5 still full", d, 8'h09);
    rdr(2'd2, d); rdr(2'd1, d); chk("R5 then cleared", d, 8'h08);

    // R9 error interrupt gating
    wrr(2'd0, 8'h04);
    rxb(8'h40); rxb(8'h41);
    chk("R9 irq_err on", irq_err, 1'b1);
    wrr(2'd0, 8'h00);
    chk("R9 irq_err gated", irq_err, 1'b0);
    rdr(2'd1, d); chk("R9 ovf kept", d, 8'h0B);
    rdr(2'd2, d); rdr(2'd1, d); chk("R9 cleared", d, 8'h08);

    // R6 master mode fault
    wrr(2'd0, 8'h10);
    ss_in = 0; idle(0); ss_in = 1; idle(0);
    rdr(2'd1, d); chk("R6 ignored without enable", d, 8'h08);
    wrr(2'd0, 8'h18);
    ss_in = 0; idle(0); ss_in = 1; idle(0);
    rdr(2'd1, d); chk("R6 fault set", d, 8'h0C);

    // R8 clear sequence for mode fault
    rdr(2'd0, d); wrr(2'd0, 8'h10);
    rdr(2'd2, d); rdr(2'd1, d); chk("R8 not cleared by enable drop", d, 8'h0C);
    wrr(2'd0, 8'h00);
    rdr(2'd1, d); chk("R8 cleared", d, 8'h08);

    // R7 slave mode fault
    wrr(2'd0, 8'h08);
    ss_in = 0; idle(0); ss_in = 1; idle(0);
    rdr(2'd1, d); chk("R7 idle edge ignored", d, 8'h08);
    ss_in = 0; idle(1); ss_in = 1; idle(1);
    rdr(2'd1, d); chk("R7 fault in transfer", d, 8'h0C);
    rdr(2'd1, d); wrr(2'd0, 8'h00);
    rdr(2'd1, d); chk("R7 cleared", d, 8'h08);

    // R10 transmit flag
    wrr(2'd0, 8'h02);
    chk("R10 irq_tx", irq_tx, 1'b1);
    wrr(2'd2, 8'h5A);
    chk("R10 tx_hold", tx_hold, 8'h5A);
    chk("R10 irq_tx off", irq_tx, 1'b0);
    step(0, 0, 2'd0, 8'h00, 0, 8'h00, 1, 0, d);
    chk("R10 irq_tx back", irq_tx, 1'b1);

    // R11 collisions
    wrr(2'd2, 8'h5B);
    step(0, 1, 2'd2, 8'h6B, 0, 8'h00, 1, 0, d);
    chk("R11 tx kept empty", irq_tx, 1'b1);
    chk("R11 tx_hold", tx_hold, 8'h6B);
    rxb(8'h44);
    rdr(2'd1, d);
    step(1, 0, 2'd2, 8'h00, 1, 8'h55, 0, 0, d);
    chk("R11 old byte read", d, 8'h44);
    rdr(2'd1, d); chk("R11 full no ovf", d, 8'h09);
    rdr(2'd2, d); chk("R11 new byte", d, 8'h55);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic r, w, rxp, txp, xa;
      logic [1:0] a;
      op = $urandom_range(0, 7);
      r = 0; w = 0; a = 2'd0;
      case (op)
        0: begin r = 1; a = 2'd1; end
        1: begin r = 1; a = 2'd2; end
        2: begin r = 1; a = 2'd0; end
        3: begin w = 1; a = 2'd2; end
        4: begin w = 1; a = 2'd0; end
        default: ;
      endcase
      rxp = ($urandom_range(0, 3) == 0);
      txp = ($urandom_range(0, 4) == 0);
      xa  = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 7) == 0) ss_in = ~ss_in;
      step(r, w, a, 8'($urandom), rxp, 8'($urandom), txp, xa, d);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule